// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers seven interrupt events from a peripheral interface chip into one active-low interrupt request. The seven sources are two timers, a shift register and four handshake lines. Each source raises a sticky flag with a one-clock strobe. The processor enables or masks each flag individually. The request line is low whenever at least one flag is pending with its enable set.

The processor reaches the block through a small register bus, made of a chip select, a 4-bit register select, a read/write line and 8-bit write and read data. Two registers live here.

- The flag register is at select value 13. Writing ones to it clears the matching flags. Its top bit reads back as a live summary of the enabled pending flags.
- The enable register is at select value 14. Bit 7 of a write chooses whether the ones in bits 0–6 set or clear enables.

Reads and writes of the port registers, which are decoded elsewhere, reach this block as clear strobes. The clear strobes for the second handshake line of each port obey a per-line independent-mode input.

Top module: `irq_flag_enable_unit`

## Requirements
- R1: After reset all flags and enables are 0, `irq_n` is 1, a flag read returns 8'h00 and an enable read returns 8'h80.
- R2: A one-clock pulse on `set_stb[i]` sets flag i on that clock edge. The bit map is 0 = port A line 2, 1 = port A line 1, 2 = shift register, 3 = port B line 2, 4 = port B line 1, 5 = timer 2, 6 = timer 1.
- R3: A write to address 13 clears each flag whose data bit (0–6) is 1 and leaves the others unchanged. Data bit 7 of that write has no effect.
- R4: A read of address 13 returns the flags in bits 0–6, and bit 7 is the OR over i of (flag[i] AND enable[i]).
- R5: `irq_n` is 0 exactly when the bit-7 summary of R4 is 1, combinationally from the current register state.
- R6: A write to address 14 with data bit 7 = 0 clears each enable whose data bit (0–6) is 1 and leaves the others unchanged.
- R7: A write to address 14 with data bit 7 = 1 sets each enable whose data bit (0–6) is 1 and leaves the others unchanged.
- R8: A read of address 14 returns 1 in bit 7 and the enables in bits 0–6.
- R9: `port_a_clr` always clears flag 1 and `port_b_clr` always clears flag 4.
- R10: `port_a_clr` clears flag 0 only while `ca2_indep` is 0. `port_b_clr` clears flag 3 only while `cb2_indep` is 0.
- R11: If a set strobe and any clear of the same flag occur in one cycle, the flag ends up set.
- R12: An access has effect only with `cs` = 1. A write needs `rw` = 0 and a read needs `rw` = 1. Any cycle that is not a read of address 13 or 14 drives `rdata` to 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the selected register |
| set_stb | input | 7 | One-clock flag set strobes, bit map as in R2 |
| port_a_clr | input | 1 | Side-effect clear from a port A register access |
| port_b_clr | input | 1 | Side-effect clear from a port B register access |
| ca2_indep | input | 1 | Port A line 2 is in independent interrupt mode |
| cb2_indep | input | 1 | Port B line 2 is in independent interrupt mode |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Directed sequences cover the following cases:
- Every source is raised alone, and the flag read is checked with its enables off, which separates the flags from the summary bit.
- Enable writes are issued with bit 7 low and high on overlapping masks, which shows whether unselected bits are disturbed.
- A write of 8'h80 to the flag register shows whether bit 7 is wrongly treated as a flag.
- Port clear strobes are repeated with the independent-mode inputs both high and low, which isolates R10 from R9.
- A set and a clear land in the same cycle, which shows the priority of R11.

Constrained random traffic then mixes bus accesses at all sixteen addresses with sparse strobes, so that collisions and unselected or deselected accesses occur often. A bench model computes each expected read value and `irq_n` level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_SRC = 7;
  localparam int unsigned IRQ_DW  = IRQ_SRC + 1;

  localparam int unsigned SRC_CA2   = 0;
  localparam int unsigned SRC_CA1   = 1;
  localparam int unsigned SRC_SHIFT = 2;
  localparam int unsigned SRC_CB2   = 3;
  localparam int unsigned SRC_CB1   = 4;
  localparam int unsigned SRC_T2    = 5;
  localparam int unsigned SRC_T1    = 6;

  typedef logic [IRQ_SRC-1:0] src_vec_t;

  // true when any pending flag has its enable set
  function automatic logic any_active(src_vec_t flags, src_vec_t enables);
    return |(flags & enables);
  endfunction

  // bit-7 steered set/clear of selected enable bits
  function automatic src_vec_t steer_enable(src_vec_t cur, src_vec_t sel, logic set_mode);
    return set_mode ? (cur | sel) : (cur & ~sel);
  endfunction

  // side-effect clear mask from port register accesses
  function automatic src_vec_t port_clear_mask(logic a_clr, logic b_clr,
                                               logic ca2_ind, logic cb2_ind);
    src_vec_t m;
    m = '0;
    m[SRC_CA1] = a_clr;
    m[SRC_CA2] = a_clr & ~ca2_ind;
    m[SRC_CB1] = b_clr;
    m[SRC_CB2] = b_clr & ~cb2_ind;
    return m;
  endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 14
) (
  input  logic              cs,
  input  logic              rw,
  input  logic [ADDR_W-1:0] rs,
  output logic              flag_wr,
  output logic              en_wr,
  output logic              flag_rd,
  output logic              en_rd
);
  logic hit_flag, hit_en, do_wr, do_rd;

  always_comb begin
    hit_flag = (rs == FLAG_ADDR);
    hit_en   = (rs == EN_ADDR);
    do_wr    = cs & ~rw;
    do_rd    = cs & rw;
    flag_wr  = do_wr & hit_flag;
    en_wr    = do_wr & hit_en;
    flag_rd  = do_rd & hit_flag;
    en_rd    = do_rd & hit_en;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_stb,
  input  logic     flag_wr,
  input  src_vec_t wr_mask,
  input  src_vec_t port_clr,
  output src_vec_t flag_q
);
  src_vec_t clr_all;
  src_vec_t flag_d;

  always_comb begin
    clr_all = port_clr | (flag_wr ? wr_mask : '0);
    // set after clear: a strobe in the same cycle survives
    flag_d  = (flag_q & ~clr_all) | set_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  for (genvar i = 0; i < IRQ_SRC; i++) begin : g_chk
    // R2 R11
    set_to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb[i] |=> flag_q[i]);
    // R3
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !set_stb[i]) |=> !flag_q[i]);
    // R3
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wr_mask[i] && !set_stb[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_wr,
  input  logic     set_mode,
  input  src_vec_t sel,
  output src_vec_t en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= steer_enable(en_q, sel, set_mode);
  end

  for (genvar i = 0; i < IRQ_SRC; i++) begin : g_chk
    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && set_mode && sel[i]) |=> en_q[i]);
    // R6
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !set_mode && sel[i]) |=> !en_q[i]);
    // R6 R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_wr && sel[i]) |=> $stable(en_q[i]));
  end
endmodule

// File: rtl/irq_read_path.sv
module irq_read_path
  import irq_pkg::*;
(
  input  logic              flag_rd,
  input  logic              en_rd,
  input  src_vec_t          flags,
  input  src_vec_t          enables,
  output logic [IRQ_DW-1:0] rdata,
  output logic              irq_n
);
  logic summary;

  always_comb begin
    summary = any_active(flags, enables);
    irq_n   = ~summary;
    if (flag_rd)    rdata = {summary, flags};
    else if (en_rd) rdata = {1'b1, enables};
    else            rdata = '0;
  end
endmodule

// File: rtl/irq_flag_enable_unit.sv
module irq_flag_enable_unit
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rw,
  input  logic [ADDR_W-1:0] rs,
  input  logic [IRQ_DW-1:0] wdata,
  output logic [IRQ_DW-1:0] rdata,
  input  logic [IRQ_SRC-1:0] set_stb,
  input  logic              port_a_clr,
  input  logic              port_b_clr,
  input  logic              ca2_indep,
  input  logic              cb2_indep,
  output logic              irq_n
);
  localparam int unsigned STEER_BIT = IRQ_DW - 1;

  logic     flag_wr, en_wr, flag_rd, en_rd;
  src_vec_t flags, enables, port_clr, data_sel;

  assign data_sel = wdata[IRQ_SRC-1:0];
  assign port_clr = port_clear_mask(port_a_clr, port_b_clr, ca2_indep, cb2_indep);

  irq_bus_decode #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)) u_dec (
    .cs(cs), .rw(rw), .rs(rs),
    .flag_wr(flag_wr), .en_wr(en_wr), .flag_rd(flag_rd), .en_rd(en_rd)
  );

  irq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .flag_wr(flag_wr),
    .wr_mask(data_sel), .port_clr(port_clr), .flag_q(flags)
  );

  irq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .set_mode(wdata[STEER_BIT]),
    .sel(data_sel), .en_q(enables)
  );

  irq_read_path u_rd (
    .flag_rd(flag_rd), .en_rd(en_rd), .flags(flags), .enables(enables),
    .rdata(rdata), .irq_n(irq_n)
  );

  // R4 R5
  summary_vs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw && rs == FLAG_ADDR) |-> (rdata[STEER_BIT] == !irq_n));
  // R8
  en_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw && rs == EN_ADDR) |-> rdata[STEER_BIT]);
  // R12
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rw) |-> (rdata == '0));
  // R10
  ca2_indep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_a_clr && ca2_indep && flags[SRC_CA2] && !(flag_wr && wdata[SRC_CA2]))
      |=> flags[SRC_CA2]);
  // R10
  cb2_indep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_b_clr && cb2_indep && flags[SRC_CB2] && !(flag_wr && wdata[SRC_CB2]))
      |=> flags[SRC_CB2]);
  // R9
  ca1_port_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_a_clr && !set_stb[SRC_CA1]) |=> !flags[SRC_CA1]);
endmodule

// File: tb/tb_irq_flag_enable_unit.sv
module tb_irq_flag_enable_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rw = 1'b1;
  logic [3:0] rs = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [6:0] set_stb = 7'd0;
  logic       port_a_clr = 1'b0, port_b_clr = 1'b0;
  logic       ca2_indep = 1'b0, cb2_indep = 1'b0;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  logic [6:0] mf = 7'd0;
  logic [6:0] me = 7'd0;

  always #10 clk = ~clk;

  irq_flag_enable_unit dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .rs(rs), .wdata(wdata),
    .rdata(rdata), .set_stb(set_stb), .port_a_clr(port_a_clr),
    .port_b_clr(port_b_clr), .ca2_indep(ca2_indep), .cb2_indep(cb2_indep),
    .irq_n(irq_n)
  );

  function automatic logic pending(logic [6:0] f, logic [6:0] e);
    logic p = 1'b0;
    for (int k = 0; k < 7; k++) if (f[k] && e[k]) p = 1'b1;
    return p;
  endfunction

  function automatic logic [7:0] exp_read(logic c, logic r, logic [3:0] a,
                                          logic [6:0] f, logic [6:0] e);
    if (!(c && r)) return 8'h00;
    if (a == 4'd13) return {pending(f, e), f};
    if (a == 4'd14) return {1'b1, e};
    return 8'h00;
  endfunction

  function automatic logic [6:0] next_flags(logic [6:0] f, logic c, logic r,
      logic [3:0] a, logic [7:0] d, logic [6:0] s, logic pa, logic pb,
      logic ia, logic ib);
    logic [6:0] n = f;
    if (c && !r && a == 4'd13) for (int k = 0; k < 7; k++) if (d[k]) n[k] = 1'b0;
    if (pa) begin n[1] = 1'b0; if (!ia) n[0] = 1'b0; end
    if (pb) begin n[4] = 1'b0; if (!ib) n[3] = 1'b0; end
    for (int k = 0; k < 7; k++) if (s[k]) n[k] = 1'b1;
    return n;
  endfunction

  function automatic logic [6:0] next_en(logic [6:0] e, logic c, logic r,
      logic [3:0] a, logic [7:0] d);
    logic [6:0] n = e;
    if (c && !r && a == 4'd14)
      for (int k = 0; k < 7; k++) if (d[k]) n[k] = d[7];
    return n;
  endfunction

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic r, input logic [3:0] a,
                     input logic [7:0] d, input logic [6:0] s, input logic pa,
                     input logic pb, input logic ia, input logic ib, input string tag);
    logic [6:0] nf, ne;
    @(negedge clk);
    cs = c; rw = r; rs = a; wdata = d; set_stb = s;
    port_a_clr = pa; port_b_clr = pb; ca2_indep = ia; cb2_indep = ib;
    #2;
    check8({7'd0, irq_n}, {7'd0, !pending(mf, me)}, {tag, " irq_n R5"});
    check8(rdata, exp_read(c, r, a, mf, me), {tag, " rdata"});
    nf = next_flags(mf, c, r, a, d, s, pa, pb, ia, ib);
    ne = next_en(me, c, r, a, d);
    @(posedge clk);
    mf = nf; me = ne;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cyc(1, 1, a, 8'h00, 7'd0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(1, 0, a, d, 7'd0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    rd(4'd13, "R1 flag");
    check8(rdata, 8'h00, "R1 flag literal");
    rd(4'd14, "R1 R8 enable");
    check8(rdata, 8'h80, "R1 R8 enable literal");
    // R2 each source alone, enables off
    for (int i = 0; i < 7; i++) begin
      cyc(0, 1, 4'd0, 8'h00, 7'(1 << i), 0, 0, 0, 0, "R2 pulse");
      rd(4'd13, "R2 R4 flag read");
      check8(rdata, {1'b0, 7'(1 << i)}, "R2 literal");
      wr(4'd13, 8'h7F, "R3 clear all");
    end
    // R7 / R6 steering
    cyc(0, 1, 4'd0, 8'h00, 7'h7F, 0, 0, 0, 0, "R2 all");
    wr(4'd14, 8'h85, "R7 set");
    rd(4'd14, "R7 read");
    check8(rdata, 8'h85, "R7 literal");
    rd(4'd13, "R4 summary");
    check8(rdata, 8'hFF, "R4 literal");
    check8({7'd0, irq_n}, 8'h00, "R5 low");
    wr(4'd14, 8'h81, "R7 reset bit");
    wr(4'd14, 8'h03, "R6 clear");
    rd(4'd14, "R6 read");
    check8(rdata, 8'h84, "R6 literal");
    // R3 bit 7 write no effect
    wr(4'd13, 8'h80, "R3 bit7");
    rd(4'd13, "R3 after bit7");
    check8(rdata, 8'hFF, "R3 literal");
    wr(4'd13, 8'h0F, "R3 partial");
    rd(4'd13, "R3 read");
    check8(rdata, 8'h70, "R3 partial literal");
    // R5 drops when enables disabled
    wr(4'd14, 8'h7F, "R5 disable");
    check8({7'd0, irq_n}, 8'h01, "R5 high");
    // R9 R10
    cyc(0, 1, 4'd0, 8'h00, 7'h7F, 0, 0, 0, 0, "R2 all");
    cyc(0, 1, 4'd0, 8'h00, 7'd0, 1, 1, 1, 1, "R9 R10 indep");
    rd(4'd13, "R10 read");
    check8(rdata, 8'h6D, "R10 indep literal");
    cyc(0, 1, 4'd0, 8'h00, 7'd0, 1, 1, 0, 0, "R10 normal");
    rd(4'd13, "R10 read2");
    check8(rdata, 8'h64, "R10 normal literal");
    // R11 set and clear together
    cyc(1, 0, 4'd13, 8'h7F, 7'h12, 1, 1, 0, 0, "R11 collide");
    rd(4'd13, "R11 read");
    check8(rdata, 8'h12, "R11 literal");
    // R12 deselected and wrong-address accesses
    cyc(0, 0, 4'd13, 8'h7F, 7'd0, 0, 0, 0, 0, "R12 cs low wr");
    cyc(1, 0, 4'd12, 8'hFF, 7'd0, 0, 0, 0, 0, "R12 other addr");
    cyc(1, 1, 4'd14, 8'hFF, 7'd0, 0, 0, 0, 0, "R12 read not write");
    rd(4'd13, "R12 read");
    check8(rdata, 8'h12, "R12 literal");
    rd(4'd5, "R12 other read");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic c, r, pa, pb, ia, ib;
      logic [3:0] a;
      logic [7:0] d;
      logic [6:0] s;
      c = ($urandom % 4) != 0;
      r = $urandom % 2;
      a = ($urandom % 3 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd13 : 4'd14);
      d = 8'($urandom);
      s = '0;
      for (int k = 0; k < 7; k++) if ($urandom % 8 == 0) s[k] = 1'b1;
      pa = ($urandom % 6) == 0;
      pb = ($urandom % 6) == 0;
      ia = $urandom % 2;
      ib = $urandom % 2;
      cyc(c, r, a, d, s, pa, pb, ia, ib, "R2 R3 R4 R6 R7 R10 R11 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule